// File: doc/BRIEF.md
# Interruption Fault-Capture Control Registers

This block holds two 64-bit control registers used by interruption handling: a faulting-address register and a translation-attribute register that later feeds a TLB insert. When the translation logic reports a fault, the block captures the faulting address. It also fills the attribute register with the page size and region identifier of the region that was accessed. Both values come from input buses, not from software.

Software may also write either register. A write to the faulting-address register always commits all 64 bits. A write to the attribute register is checked field by field before it commits. The reserved fields must be zero, the page size must be one the implementation supports, and the protection-key bits above the implemented width must be zero. If any check fails, the register keeps its old value and a one-cycle reserved-field fault pulse goes out to the interrupt logic.

Attribute register layout:
- bits 1:0 are reserved.
- bits 7:2 hold the page size (6 bits).
- bits 31:8 hold the protection key (24 bits).
- bits 63:32 are reserved.

Top module: `intr_capture_regs`

## Requirements
- R1: After reset both registers read zero and `rsv_fault` is low.
- R2: On `flt_valid`, the attribute register becomes `{32'b0, rgn_id, rgn_page_size, 2'b00}`. The key sits at bits 31:8 and the page size at bits 7:2, and the reserved fields are cleared.
- R3: On `flt_valid` with `flt_second_page` low, the address register captures all 64 bits of `flt_addr` unchanged.
- R4: On `flt_valid` with `flt_second_page` high, the address register captures `flt_addr` with its low `BUNDLE_ALIGN_BITS` bits (default 4) cleared.
- R5: A software write to the address register (`sw_addr_we`) commits all 64 bits of `sw_addr_wdata`.
- R6: A software attribute write that passes every check commits `sw_attr_wdata` exactly and leaves `rsv_fault` low.
- R7: A software attribute write with any non-zero bit in bits 1:0 or 63:32 is rejected. The register is unchanged and `rsv_fault` is high in the next cycle.
- R8: A software attribute write whose page size p (bits 7:2) has bit p of `PS_SUPPORT_MASK` clear is rejected. The default mask supports sizes 12, 13, 14, 16, 18, 20, 22, 24, 26 and 28.
- R9: A software attribute write with any non-zero key bit at position 8+`KEY_IMPL_BITS` or above within bits 31:8 is rejected. The default is 18 implemented key bits, so bits 31:26 must be zero.
- R10: `rsv_fault` is a registered pulse. It is high for exactly the one cycle after each rejected write, and low in the cycle after any non-rejected one.
- R11: When `flt_valid` arrives in the same cycle as a software write, the fault capture wins. The software writes are discarded and no `rsv_fault` is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flt_valid | input | 1 | Translation-fault capture strobe |
| flt_addr | input | 64 | Address of the faulting access |
| flt_second_page | input | 1 | Fault hit the second page of a page-crossing access |
| rgn_page_size | input | 6 | Page size of the accessed region |
| rgn_id | input | 24 | Identifier of the accessed region |
| sw_addr_we | input | 1 | Software write strobe, address register |
| sw_addr_wdata | input | 64 | Software write data, address register |
| sw_attr_we | input | 1 | Software write strobe, attribute register |
| sw_attr_wdata | input | 64 | Software write data, attribute register |
| addr_rdata | output | 64 | Current address register contents |
| attr_rdata | output | 64 | Current attribute register contents |
| rsv_fault | output | 1 | One-cycle reserved-field fault pulse |

## Verification
Every result is registered once. Register contents and the `rsv_fault` pulse change at the first rising edge after a strobe is presented, and `rsv_fault` must be low again one edge later. The bench drives a stimulus on a falling edge and samples at the next falling edge, which is one full cycle later. For the pulse checks it samples once more a cycle after that. Rejected writes are checked by reading the attribute register back in the same sample as the pulse, so an unwanted commit is visible at the ports.

// File: rtl/icr_pkg.sv
package icr_pkg;
    localparam int REG_W   = 64;
    localparam int PS_LSB  = 2;
    localparam int PS_W    = 6;
    localparam int KEY_LSB = 8;
    localparam int KEY_W   = 24;
    localparam int RSV_HI_LSB = KEY_LSB + KEY_W;

    typedef struct packed {
        logic [REG_W-1:0] addr;
        logic [REG_W-1:0] attr;
        logic             rsv_flt;
    } icr_state_t;

    function automatic logic [REG_W-1:0] pack_attr(input logic [PS_W-1:0] ps,
                                                   input logic [KEY_W-1:0] key);
        logic [REG_W-1:0] w;
        w = '0;
        w[PS_LSB +: PS_W]   = ps;
        w[KEY_LSB +: KEY_W] = key;
        return w;
    endfunction
endpackage

// File: rtl/attr_wr_check.sv
module attr_wr_check
    import icr_pkg::*;
#(
    parameter logic [63:0] PS_SUPPORT_MASK = 64'h0000_0000_1555_7000,
    parameter int          KEY_IMPL_BITS   = 18
) (
    input  logic [REG_W-1:0] wdata,
    output logic             reject
);
    localparam int KEY_TOP_W = KEY_W - KEY_IMPL_BITS;

    logic rsv_bad;
    logic ps_bad;
    logic key_bad;
    logic [PS_W-1:0] ps_val;

    assign ps_val  = wdata[PS_LSB +: PS_W];
    assign rsv_bad = (|wdata[PS_LSB-1:0]) || (|wdata[REG_W-1:RSV_HI_LSB]);
    assign ps_bad  = !PS_SUPPORT_MASK[ps_val];

    generate
        if (KEY_TOP_W > 0) begin : g_key_chk
            assign key_bad = |wdata[KEY_LSB+KEY_W-1 : KEY_LSB+KEY_IMPL_BITS];
        end else begin : g_key_full
            assign key_bad = 1'b0;
        end
    endgenerate

    assign reject = rsv_bad || ps_bad || key_bad;
endmodule

// File: rtl/fault_addr_sel.sv
module fault_addr_sel
    import icr_pkg::*;
#(
    parameter int BUNDLE_ALIGN_BITS = 4
) (
    input  logic [REG_W-1:0] flt_addr,
    input  logic             second_page,
    output logic [REG_W-1:0] cap_addr
);
    logic [REG_W-1:0] bundle_addr;

    assign bundle_addr = {flt_addr[REG_W-1:BUNDLE_ALIGN_BITS], {BUNDLE_ALIGN_BITS{1'b0}}};
    assign cap_addr    = second_page ? bundle_addr : flt_addr;
endmodule

// File: rtl/intr_capture_regs.sv
module intr_capture_regs
    import icr_pkg::*;
#(
    parameter logic [63:0] PS_SUPPORT_MASK   = 64'h0000_0000_1555_7000,
    parameter int          KEY_IMPL_BITS     = 18,
    parameter int          BUNDLE_ALIGN_BITS = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         flt_valid,
    input  logic [63:0]  flt_addr,
    input  logic         flt_second_page,
    input  logic [5:0]   rgn_page_size,
    input  logic [23:0]  rgn_id,
    input  logic         sw_addr_we,
    input  logic [63:0]  sw_addr_wdata,
    input  logic         sw_attr_we,
    input  logic [63:0]  sw_attr_wdata,
    output logic [63:0]  addr_rdata,
    output logic [63:0]  attr_rdata,
    output logic         rsv_fault
);
    icr_state_t st_d, st_q;
    logic [REG_W-1:0] cap_addr;
    logic             wr_reject;

    fault_addr_sel #(.BUNDLE_ALIGN_BITS(BUNDLE_ALIGN_BITS)) i_addr_sel (
        .flt_addr   (flt_addr),
        .second_page(flt_second_page),
        .cap_addr   (cap_addr)
    );

    attr_wr_check #(.PS_SUPPORT_MASK(PS_SUPPORT_MASK), .KEY_IMPL_BITS(KEY_IMPL_BITS)) i_wr_check (
        .wdata (sw_attr_wdata),
        .reject(wr_reject)
    );

    always_comb begin
        st_d         = st_q;
        st_d.rsv_flt = 1'b0;
        if (flt_valid) begin
            st_d.addr = cap_addr;
            st_d.attr = pack_attr(rgn_page_size, rgn_id);
        end else begin
            if (sw_addr_we) begin
                st_d.addr = sw_addr_wdata;
            end
            if (sw_attr_we) begin
                if (wr_reject) begin
                    st_d.rsv_flt = 1'b1;
                end else begin
                    st_d.attr = sw_attr_wdata;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign addr_rdata = st_q.addr;
    assign attr_rdata = st_q.attr;
    assign rsv_fault  = st_q.rsv_flt;

    // R2
    capture_rsv_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flt_valid |=> (attr_rdata[63:32] == '0) && (attr_rdata[1:0] == '0));

    // R7
    reject_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsv_fault |-> $stable(attr_rdata));

    // R10
    pulse_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsv_fault |-> $past(sw_attr_we && !flt_valid));

    // R11
    fault_priority_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flt_valid |=> !rsv_fault);

    // R6
    accept_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_attr_we && !flt_valid && !wr_reject) |=> (attr_rdata == $past(sw_attr_wdata)));

    // R5
    addr_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_addr_we && !flt_valid) |=> (addr_rdata == $past(sw_addr_wdata)));
endmodule

// File: tb/test_intr_capture_regs.sv
module test_intr_capture_regs;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        flt_valid = 1'b0;
    logic [63:0] flt_addr = '0;
    logic        flt_second_page = 1'b0;
    logic [5:0]  rgn_page_size = '0;
    logic [23:0] rgn_id = '0;
    logic        sw_addr_we = 1'b0;
    logic [63:0] sw_addr_wdata = '0;
    logic        sw_attr_we = 1'b0;
    logic [63:0] sw_attr_wdata = '0;
    logic [63:0] addr_rdata;
    logic [63:0] attr_rdata;
    logic        rsv_fault;

    int n_run = 0;
    int n_fail = 0;
    bit done = 0;

    always #4 clk = ~clk;

    intr_capture_regs i_intr_capture_regs (
        .clk(clk), .rst_n(rst_n), .flt_valid(flt_valid), .flt_addr(flt_addr),
        .flt_second_page(flt_second_page), .rgn_page_size(rgn_page_size), .rgn_id(rgn_id),
        .sw_addr_we(sw_addr_we), .sw_addr_wdata(sw_addr_wdata),
        .sw_attr_we(sw_attr_we), .sw_attr_wdata(sw_attr_wdata),
        .addr_rdata(addr_rdata), .attr_rdata(attr_rdata), .rsv_fault(rsv_fault)
    );

    typedef struct packed {
        logic [1:0]  op;
        logic [63:0] data;
        logic        sec;
        logic [5:0]  ps;
        logic [23:0] rid;
        logic [63:0] exp_addr;
        logic [63:0] exp_attr;
        logic        exp_flt;
    } vec_t;

    localparam vec_t VECS [9] = '{
        '{2'd0, 64'hFEDC_BA98_7654_3217, 1'b0, 6'd14, 24'hABCDEF, 64'hFEDC_BA98_7654_3217, 64'h0000_0000_ABCD_EF38, 1'b0},
        '{2'd0, 64'h0000_7FFF_0000_10FF, 1'b1, 6'd12, 24'h000001, 64'h0000_7FFF_0000_10F0, 64'h0000_0000_0000_0130, 1'b0},
        '{2'd1, 64'h8000_0000_0000_0001, 1'b0, 6'd0,  24'h0,      64'h8000_0000_0000_0001, 64'h0000_0000_0000_0130, 1'b0},
        '{2'd2, 64'h0000_0000_03FF_FF40, 1'b0, 6'd0,  24'h0,      64'h8000_0000_0000_0001, 64'h0000_0000_03FF_FF40, 1'b0},
        '{2'd2, 64'h0000_0000_0000_0051, 1'b0, 6'd0,  24'h0,      64'h8000_0000_0000_0001, 64'h0000_0000_03FF_FF40, 1'b1},
        '{2'd2, 64'h0000_0001_0000_0050, 1'b0, 6'd0,  24'h0,      64'h8000_0000_0000_0001, 64'h0000_0000_03FF_FF40, 1'b1},
        '{2'd2, 64'h0000_0000_0000_123C, 1'b0, 6'd0,  24'h0,      64'h8000_0000_0000_0001, 64'h0000_0000_03FF_FF40, 1'b1},
        '{2'd2, 64'h0000_0000_0400_0050, 1'b0, 6'd0,  24'h0,      64'h8000_0000_0000_0001, 64'h0000_0000_03FF_FF40, 1'b1},
        '{2'd2, 64'h0000_0000_0000_0170, 1'b0, 6'd0,  24'h0,      64'h8000_0000_0000_0001, 64'h0000_0000_0000_0170, 1'b0}
    };
    // Requirement covered by each vector: R3 R2, R4, R5, R6, R7, R7, R8, R9, R6
    localparam string VREQ [9] = '{"R3", "R4", "R5", "R6", "R7", "R7", "R8", "R9", "R6"};

    task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic clear_inputs();
        flt_valid = 1'b0; flt_second_page = 1'b0;
        sw_addr_we = 1'b0; sw_attr_we = 1'b0;
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1", "addr", addr_rdata, 64'h0);
        chk("R1", "attr", attr_rdata, 64'h0);
        chk("R1", "flt",  {63'h0, rsv_fault}, 64'h0);
        rst_n = 1'b1;

        for (int i = 0; i < 9; i++) begin
            @(negedge clk);
            clear_inputs();
            case (VECS[i].op)
                2'd0: begin
                    flt_valid = 1'b1; flt_addr = VECS[i].data; flt_second_page = VECS[i].sec;
                    rgn_page_size = VECS[i].ps; rgn_id = VECS[i].rid;
                end
                2'd1: begin sw_addr_we = 1'b1; sw_addr_wdata = VECS[i].data; end
                default: begin sw_attr_we = 1'b1; sw_attr_wdata = VECS[i].data; end
            endcase
            @(negedge clk);
            chk(VREQ[i], "addr", addr_rdata, VECS[i].exp_addr);
            chk(i == 0 ? "R2" : VREQ[i], "attr", attr_rdata, VECS[i].exp_attr);
            chk(VREQ[i], "flt", {63'h0, rsv_fault}, {63'h0, VECS[i].exp_flt});
            clear_inputs();
        end

        // R10: pulse lasts one cycle after a rejected write
        @(negedge clk);
        chk("R10", "flt low after pulse", {63'h0, rsv_fault}, 64'h0);

        // R10: back-to-back rejects give one pulse each, then low
        sw_attr_we = 1'b1; sw_attr_wdata = 64'h0000_0000_0000_0002;
        @(negedge clk);
        chk("R10", "first pulse", {63'h0, rsv_fault}, 64'h1);
        sw_attr_wdata = 64'h0000_0000_0000_0178;   // ps 30 unsupported
        @(negedge clk);
        chk("R10", "second pulse", {63'h0, rsv_fault}, 64'h1);
        chk("R8", "attr kept", attr_rdata, 64'h0000_0000_0000_0170);
        clear_inputs();
        @(negedge clk);
        chk("R10", "pulse ends", {63'h0, rsv_fault}, 64'h0);

        // R11: fault together with a bad attr write and an addr write
        flt_valid = 1'b1; flt_addr = 64'h1234_5678_9ABC_DEF1; flt_second_page = 1'b1;
        rgn_page_size = 6'd20; rgn_id = 24'h00_0042;
        sw_addr_we = 1'b1; sw_addr_wdata = 64'hDEAD_BEEF_0000_0000;
        sw_attr_we = 1'b1; sw_attr_wdata = 64'hFFFF_FFFF_FFFF_FFFF;
        @(negedge clk);
        chk("R11", "addr from fault", addr_rdata, 64'h1234_5678_9ABC_DEF0);
        chk("R11", "attr from fault", attr_rdata, 64'h0000_0000_0000_4250);
        chk("R11", "no pulse", {63'h0, rsv_fault}, 64'h0);
        clear_inputs();

        // R11: fault with a valid attr write, fault still wins
        flt_valid = 1'b1; flt_addr = 64'h0; rgn_page_size = 6'd13; rgn_id = 24'hFFFFFF;
        sw_attr_we = 1'b1; sw_attr_wdata = 64'h0000_0000_0000_0170;
        @(negedge clk);
        chk("R11", "attr fault wins", attr_rdata, 64'h0000_0000_FFFF_FF34);
        clear_inputs();

        // R1: reset clears again
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1", "addr after reset", addr_rdata, 64'h0);
        chk("R1", "attr after reset", attr_rdata, 64'h0);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule